// File: doc/BRIEF.md
# Transmit Message Box Priority Selector

This block decides which message box a CAN controller transmits next. Each of the message boxes (16 by default) presents a pending-transmission flag, a flag that says whether its identifier is in the 11-bit base format or the 29-bit extended format, and a 29-bit identifier field. A separate count input says how many of the lowest-numbered boxes are in use. Boxes at or above that count never take part.

When the protocol engine pulses the selection strobe, the block runs a comparison tree over all eligible boxes. One clock later it registers the winning box number and a valid flag. The result stays put until the next strobe. When the engine reports a successful transmission, the block issues a one-cycle, one-hot clear pulse toward the register holding the winner's pending flag, and withdraws its valid flag.

Failed transmissions produce no clear pulse. The pending flag stays set, so the same box competes again at the next strobe.

Top module: `tx_prio_sel`

## Requirements
- R1: On the clock edge that samples `sel_start` high (with `tx_done_ok` low), `sel_valid` and `sel_idx` are loaded with the selection made from the inputs sampled on that same edge. The result is visible after that edge.
- R2: A box k is eligible only when its bit in `box_req` is 1 and k < `box_count`. A count of 0 makes no box eligible. A count of 16 or more makes every box eligible.
- R3: Among eligible boxes, the one with the numerically lowest comparison key wins. Identifiers are compared from the most significant bit down, so a 0 beats a 1 at the first differing bit.
- R4: The identifier of a base-format box lies in bits [10:0] of its 29-bit `box_id` slice and is compared as if it sat in the top 11 bits. When the top 11 bits are equal, a base-format box beats an extended one. Between extended boxes, bits [17:0] decide next.
- R5: When two eligible boxes have equal keys, the lower box number wins.
- R6: When no box is eligible, a selection drives `sel_valid` low.
- R7: Without a strobe or a completion, `sel_valid` and `sel_idx` keep their values, even when the box inputs change.
- R8: A `tx_done_ok` pulse while `sel_valid` is 1 makes `clr_req` equal to 1 shifted left by `sel_idx` for exactly the next cycle, and drops `sel_valid`. A `tx_done_ok` pulse while `sel_valid` is 0 produces no clear.
- R9: When `sel_start` and `tx_done_ok` are high on the same edge, the completion is served and the strobe is ignored.
- R10: A clock edge with `rst_n` low clears `sel_valid`, `sel_idx` and `clr_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| box_req | input | NUM_BOX | Pending-transmission flag per box |
| box_ext | input | NUM_BOX | 1 = extended 29-bit identifier, 0 = 11-bit base identifier |
| box_id | input | NUM_BOX*29 | Identifier field per box; box k occupies bits [29k+28:29k] |
| box_count | input | CNT_W (5) | Number of boxes in use, counted from box 0 |
| sel_start | input | 1 | Selection strobe |
| tx_done_ok | input | 1 | Successful completion of the selected box's transmission |
| sel_idx | output | IDX_W (4) | Number of the selected box |
| sel_valid | output | 1 | A box has been selected and is pending |
| clr_req | output | NUM_BOX | One-cycle one-hot clear for the winner's pending flag |

## Verification
The assertions on the selection result assume that the box inputs are sampled only on the strobe edge. They rebuild eligibility and keys from values captured on that edge, not from later values.

They also assume that `tx_done_ok` arrives as a single-cycle pulse, and that the register file applies `clr_req` itself. The bench therefore changes box inputs only at falling edges, between selections. It issues every strobe and completion as a one-cycle pulse, and it models the clearing of the pending flag explicitly where a test needs it.

// File: rtl/tps_pkg.sv
// Shared widths and the identifier-to-key mapping for the transmit priority selector.
// Assumes identifier slices are 29 bits wide, with base identifiers in the low 11 bits.
package tps_pkg;
    localparam int STD_W = 11;
    localparam int EXT_W = 29;
    localparam int LOW_W = EXT_W - STD_W;
    localparam int KEY_W = EXT_W + 1;

    typedef logic [KEY_W-1:0] key_t;

    // Key layout: top 11 identifier bits, format bit (base = 0), low 18 bits.
    function automatic key_t make_key(input logic is_ext, input logic [EXT_W-1:0] raw);
        key_t k;
        if (is_ext) begin
            k = {raw[EXT_W-1:LOW_W], 1'b1, raw[LOW_W-1:0]};
        end else begin
            k = {raw[STD_W-1:0], 1'b0, {LOW_W{1'b0}}};
        end
        return k;
    endfunction
endpackage

// File: rtl/tps_key_gen.sv
// Builds a comparison key and an eligibility bit for every box.
// Assumes box_count counts boxes from number 0 upward.
module tps_key_gen #(
    parameter int NUM_BOX = 16,
    parameter int CNT_W   = $clog2(NUM_BOX + 1)
) (
    input  logic [NUM_BOX-1:0]                    box_req,
    input  logic [NUM_BOX-1:0]                    box_ext,
    input  logic [NUM_BOX*tps_pkg::EXT_W-1:0]     box_id,
    input  logic [CNT_W-1:0]                      box_count,
    output logic [NUM_BOX-1:0]                    elig,
    output tps_pkg::key_t [NUM_BOX-1:0]           keys
);
    localparam int IW = tps_pkg::EXT_W;

    for (genvar k = 0; k < NUM_BOX; k++) begin : g_box
        // Per-box eligibility: pending and below the in-use count.
        always_comb begin
            elig[k] = box_req[k] && (CNT_W'(k) < box_count);
        end
        // Per-box key formation with base-format alignment.
        always_comb begin
            keys[k] = tps_pkg::make_key(box_ext[k], box_id[k*IW +: IW]);
        end
    end
endmodule

// File: rtl/tps_node.sv
// One two-input comparison stage of the selection tree.
// Assumes the a-side always carries lower box numbers than the b-side.
module tps_node #(
    parameter int IDX_W = 4
) (
    input  logic                 a_vld,
    input  tps_pkg::key_t        a_key,
    input  logic [IDX_W-1:0]     a_idx,
    input  logic                 b_vld,
    input  tps_pkg::key_t        b_key,
    input  logic [IDX_W-1:0]     b_idx,
    output logic                 o_vld,
    output tps_pkg::key_t        o_key,
    output logic [IDX_W-1:0]     o_idx
);
    logic take_a;

    // Pick a on lower key or equal key; an invalid side always loses.
    always_comb begin
        take_a = a_vld && (!b_vld || (a_key <= b_key));
        o_vld  = a_vld || b_vld;
        o_key  = take_a ? a_key : b_key;
        o_idx  = take_a ? a_idx : b_idx;
    end
endmodule

// File: rtl/tps_tree.sv
// Balanced reduction tree that finds the eligible box with the lowest key.
// Assumes NUM_BOX >= 2; missing leaves up to the next power of two are invalid.
module tps_tree #(
    parameter int NUM_BOX = 16,
    parameter int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic [NUM_BOX-1:0]            elig,
    input  tps_pkg::key_t [NUM_BOX-1:0]   keys,
    output logic                          win_vld,
    output logic [IDX_W-1:0]              win_idx
);
    localparam int PAD  = 1 << IDX_W;
    localparam int LVLS = IDX_W;

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int N = PAD >> l;
        logic [N-1:0]                    vld;
        tps_pkg::key_t [N-1:0]           key;
        logic [N-1:0][IDX_W-1:0]         idx;

        if (l == 0) begin : g_leaf
            for (genvar n = 0; n < N; n++) begin : g_n
                if (n < NUM_BOX) begin : g_real
                    // Leaf load from the key generator.
                    always_comb begin
                        vld[n] = elig[n];
                        key[n] = keys[n];
                        idx[n] = IDX_W'(n);
                    end
                end else begin : g_pad
                    // Padding leaf that can never win.
                    always_comb begin
                        vld[n] = 1'b0;
                        key[n] = '1;
                        idx[n] = IDX_W'(n);
                    end
                end
            end
        end else begin : g_inner
            for (genvar n = 0; n < N; n++) begin : g_n
                tps_node #(.IDX_W(IDX_W)) u_node (
                    .a_vld (g_lvl[l-1].vld[2*n]),
                    .a_key (g_lvl[l-1].key[2*n]),
                    .a_idx (g_lvl[l-1].idx[2*n]),
                    .b_vld (g_lvl[l-1].vld[2*n+1]),
                    .b_key (g_lvl[l-1].key[2*n+1]),
                    .b_idx (g_lvl[l-1].idx[2*n+1]),
                    .o_vld (vld[n]),
                    .o_key (key[n]),
                    .o_idx (idx[n])
                );
            end
        end
    end

    logic root_take_a;

    // Final stage: only validity and box number leave the tree.
    always_comb begin
        root_take_a = g_lvl[LVLS-1].vld[0] &&
                      (!g_lvl[LVLS-1].vld[1] ||
                       (g_lvl[LVLS-1].key[0] <= g_lvl[LVLS-1].key[1]));
        win_vld = g_lvl[LVLS-1].vld[0] || g_lvl[LVLS-1].vld[1];
        win_idx = root_take_a ? g_lvl[LVLS-1].idx[0] : g_lvl[LVLS-1].idx[1];
    end
endmodule

// File: rtl/tps_ctrl.sv
// Result register and completion handling for the selector.
// Assumes tx_done_ok is a single-cycle pulse; completion outranks a strobe.
module tps_ctrl #(
    parameter int NUM_BOX = 16,
    parameter int IDX_W   = $clog2(NUM_BOX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_start,
    input  logic                 tx_done_ok,
    input  logic                 win_vld,
    input  logic [IDX_W-1:0]     win_idx,
    output logic [IDX_W-1:0]     sel_idx,
    output logic                 sel_valid,
    output logic [NUM_BOX-1:0]   clr_req
);
    localparam logic [NUM_BOX-1:0] ONE = NUM_BOX'(1);

    // Hold the winner, load it on a strobe, retire it on successful completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx   <= '0;
            sel_valid <= 1'b0;
            clr_req   <= '0;
        end else begin
            clr_req <= '0;
            if (tx_done_ok) begin
                if (sel_valid) begin
                    clr_req   <= ONE << sel_idx;
                    sel_valid <= 1'b0;
                end
            end else if (sel_start) begin
                sel_valid <= win_vld;
                sel_idx   <= win_idx;
            end
        end
    end
endmodule

// File: rtl/tx_prio_sel.sv
// Top of the transmit priority selector: key generation, comparison tree, result register.
// Assumes box inputs are stable around the strobe edge and NUM_BOX >= 2.
module tx_prio_sel #(
    parameter int NUM_BOX = 16,
    parameter int IDX_W   = $clog2(NUM_BOX),
    parameter int CNT_W   = $clog2(NUM_BOX + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_BOX-1:0]                    box_req,
    input  logic [NUM_BOX-1:0]                    box_ext,
    input  logic [NUM_BOX*tps_pkg::EXT_W-1:0]     box_id,
    input  logic [CNT_W-1:0]                      box_count,
    input  logic                                  sel_start,
    input  logic                                  tx_done_ok,
    output logic [IDX_W-1:0]                      sel_idx,
    output logic                                  sel_valid,
    output logic [NUM_BOX-1:0]                    clr_req
);
    logic [NUM_BOX-1:0]            elig;
    tps_pkg::key_t [NUM_BOX-1:0]   keys;
    logic                          win_vld;
    logic [IDX_W-1:0]              win_idx;

    tps_key_gen #(.NUM_BOX(NUM_BOX), .CNT_W(CNT_W)) u_keys (
        .box_req   (box_req),
        .box_ext   (box_ext),
        .box_id    (box_id),
        .box_count (box_count),
        .elig      (elig),
        .keys      (keys)
    );

    tps_tree #(.NUM_BOX(NUM_BOX), .IDX_W(IDX_W)) u_tree (
        .elig    (elig),
        .keys    (keys),
        .win_vld (win_vld),
        .win_idx (win_idx)
    );

    tps_ctrl #(.NUM_BOX(NUM_BOX), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_start  (sel_start),
        .tx_done_ok (tx_done_ok),
        .win_vld    (win_vld),
        .win_idx    (win_idx),
        .sel_idx    (sel_idx),
        .sel_valid  (sel_valid),
        .clr_req    (clr_req)
    );
endmodule

// File: rtl/tps_chk.sv
// Property checker for tx_prio_sel, attached with bind.
// Captures the box inputs on each accepted strobe and checks the registered result against them.
module tps_chk #(
    parameter int NUM_BOX = 16,
    parameter int IDX_W   = $clog2(NUM_BOX),
    parameter int CNT_W   = $clog2(NUM_BOX + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_BOX-1:0]                    box_req,
    input  logic [NUM_BOX-1:0]                    box_ext,
    input  logic [NUM_BOX*tps_pkg::EXT_W-1:0]     box_id,
    input  logic [CNT_W-1:0]                      box_count,
    input  logic                                  sel_start,
    input  logic                                  tx_done_ok,
    input  logic [IDX_W-1:0]                      sel_idx,
    input  logic                                  sel_valid,
    input  logic [NUM_BOX-1:0]                    clr_req
);
    localparam int IW = tps_pkg::EXT_W;

    logic                          q_sel;
    logic [NUM_BOX-1:0]            q_req;
    logic [NUM_BOX-1:0]            q_ext;
    logic [NUM_BOX*IW-1:0]         q_id;
    logic [CNT_W-1:0]              q_cnt;
    logic                          any_elig;
    logic                          better;
    tps_pkg::key_t                 win_key;

    // Snapshot of the inputs on an accepted strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sel <= 1'b0;
            q_req <= '0;
            q_ext <= '0;
            q_id  <= '0;
            q_cnt <= '0;
        end else begin
            q_sel <= sel_start && !tx_done_ok;
            q_req <= box_req;
            q_ext <= box_ext;
            q_id  <= box_id;
            q_cnt <= box_count;
        end
    end

    // Linear reference scan: is any box eligible, and does one beat the reported winner?
    always_comb begin
        any_elig = 1'b0;
        better   = 1'b0;
        win_key  = tps_pkg::make_key(q_ext[sel_idx], q_id[sel_idx*IW +: IW]);
        for (int k = 0; k < NUM_BOX; k++) begin
            if (q_req[k] && (CNT_W'(k) < q_cnt)) begin
                any_elig = 1'b1;
                if ((tps_pkg::make_key(q_ext[k], q_id[k*IW +: IW]) < win_key) ||
                    ((tps_pkg::make_key(q_ext[k], q_id[k*IW +: IW]) == win_key) &&
                     (k < int'(sel_idx)))) begin
                    better = 1'b1;
                end
            end
        end
    end

    p_valid_on_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sel && any_elig) |-> sel_valid);

    p_winner_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sel && sel_valid) |-> (q_req[sel_idx] && (CNT_W'(sel_idx) < q_cnt)));

    // Covers R3, R4 and R5 through the key and index ordering.
    p_no_better_box_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sel && sel_valid) |-> !better);

    p_none_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sel && !any_elig) |-> !sel_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_start && !tx_done_ok) |=> ($stable(sel_valid) && $stable(sel_idx)));

    p_clear_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_req));

    p_clear_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req != '0) |-> ($past(tx_done_ok && sel_valid) && clr_req[$past(sel_idx)]));

    p_done_retires_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_ok |=> !sel_valid);

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (!sel_valid && (clr_req == '0) && (sel_idx == '0)));
endmodule

bind tx_prio_sel tps_chk #(.NUM_BOX(NUM_BOX), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .box_req    (box_req),
    .box_ext    (box_ext),
    .box_id     (box_id),
    .box_count  (box_count),
    .sel_start  (sel_start),
    .tx_done_ok (tx_done_ok),
    .sel_idx    (sel_idx),
    .sel_valid  (sel_valid),
    .clr_req    (clr_req)
);

// File: tb/tx_prio_sel_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed corner cases.
module tx_prio_sel_tb_top;
    localparam int NB = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NB-1:0]     box_req;
    logic [NB-1:0]     box_ext;
    logic [NB*29-1:0]  box_id;
    logic [4:0]        box_count;
    logic              sel_start;
    logic              tx_done_ok;
    logic [3:0]        sel_idx;
    logic              sel_valid;
    logic [NB-1:0]     clr_req;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tx_prio_sel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .box_req    (box_req),
        .box_ext    (box_ext),
        .box_id     (box_id),
        .box_count  (box_count),
        .sel_start  (sel_start),
        .tx_done_ok (tx_done_ok),
        .sel_idx    (sel_idx),
        .sel_valid  (sel_valid),
        .clr_req    (clr_req)
    );

    // Vector: request mask, extended mask, count, expected valid, expected box.
    typedef struct packed {
        logic [15:0] req;
        logic [15:0] ext;
        logic [4:0]  cnt;
        logic        vld;
        logic [3:0]  idx;
    } vec_t;

    // Box k carries top-11 value 100 + (7k mod 16) and low bits k.
    localparam vec_t VECS [12] = '{
        '{16'hFFFF, 16'h0000, 5'd16, 1'b1, 4'd0},
        '{16'hFFFE, 16'h0000, 5'd16, 1'b1, 4'd7},
        '{16'hFFFE, 16'h0000, 5'd7,  1'b1, 4'd5},
        '{16'h0006, 16'h0000, 5'd16, 1'b1, 4'd1},
        '{16'h0000, 16'h0000, 5'd16, 1'b0, 4'd0},
        '{16'h8000, 16'h0000, 5'd15, 1'b0, 4'd0},
        '{16'h8000, 16'h0000, 5'd16, 1'b1, 4'd15},
        '{16'h0210, 16'h0000, 5'd16, 1'b1, 4'd4},
        '{16'hFFFF, 16'h0000, 5'd0,  1'b0, 4'd0},
        '{16'hFFFF, 16'h0000, 5'd1,  1'b1, 4'd0},
        '{16'h4020, 16'hFFFF, 5'd16, 1'b1, 4'd14},
        '{16'h1008, 16'h1000, 5'd16, 1'b1, 4'd12}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    endtask

    task automatic put_id(input int k, input logic ext, input logic [10:0] top, input logic [17:0] low);
        box_ext[k] = ext;
        box_id[k*29 +: 29] = ext ? {top, low} : {18'd0, top};
    endtask

    task automatic select();
        @(negedge clk) sel_start = 1'b1;
        @(negedge clk) sel_start = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk) tx_done_ok = 1'b1;
        @(negedge clk) tx_done_ok = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        rst_n = 1'b0; box_req = '0; box_ext = '0; box_id = '0;
        box_count = 5'd16; sel_start = 1'b0; tx_done_ok = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 valid", int'(sel_valid), 0);
        check("R10 idx", int'(sel_idx), 0);
        check("R10 clr", int'(clr_req), 0);
        rst_n = 1'b1;

        // Table walk: R1, R2, R3, R6 under varied masks and counts.
        for (int v = 0; v < 12; v++) begin
            for (int k = 0; k < NB; k++) begin
                put_id(k, VECS[v].ext[k], 11'(100 + ((k * 7) % 16)), 18'(k));
            end
            box_req = VECS[v].req;
            box_count = VECS[v].cnt;
            select();
            check($sformatf("R1/R2/R6 vec%0d valid", v), int'(sel_valid), int'(VECS[v].vld));
            if (VECS[v].vld) check($sformatf("R1/R3 vec%0d idx", v), int'(sel_idx), int'(VECS[v].idx));
        end

        // R4: base identifier beats an extended one with the same top bits.
        box_id = '0; box_ext = '0; box_count = 5'd16;
        put_id(2, 1'b1, 11'd50, 18'd0);
        put_id(9, 1'b0, 11'd50, 18'd0);
        box_req = 16'h0204;
        select();
        check("R4 base before ext", int'(sel_idx), 9);

        // R4: extended boxes compare their low bits after equal top bits.
        put_id(4, 1'b1, 11'd30, 18'd5);
        put_id(5, 1'b1, 11'd30, 18'd2);
        box_req = 16'h0030;
        select();
        check("R4 ext low bits", int'(sel_idx), 5);

        // R3: first differing bit from the top decides.
        put_id(1, 1'b0, 11'h400, 18'd0);
        put_id(2, 1'b0, 11'h3FF, 18'd0);
        box_req = 16'h0006;
        select();
        check("R3 msb first", int'(sel_idx), 2);

        // R5: equal keys go to the lower box number.
        put_id(10, 1'b1, 11'd7, 18'd9);
        put_id(11, 1'b1, 11'd7, 18'd9);
        box_req = 16'h0C00;
        select();
        check("R5 ext tie", int'(sel_idx), 10);
        put_id(3, 1'b0, 11'd20, 18'd0);
        put_id(6, 1'b0, 11'd20, 18'd0);
        box_req = 16'h0048;
        select();
        check("R5 base tie", int'(sel_idx), 3);

        // R7: changing inputs without a strobe leaves the result alone.
        box_req = 16'h0001; box_count = 5'd0;
        repeat (2) @(negedge clk);
        check("R7 hold valid", int'(sel_valid), 1);
        check("R7 hold idx", int'(sel_idx), 3);

        // R8: completion clears the winner's flag for one cycle.
        box_count = 5'd16;
        done_pulse();
        check("R8 clr onehot", int'(clr_req), 1 << 3);
        check("R8 valid dropped", int'(sel_valid), 0);
        @(negedge clk);
        check("R8 clr one cycle", int'(clr_req), 0);
        done_pulse();
        check("R8 no clr without valid", int'(clr_req), 0);

        // R9: strobe together with completion is ignored.
        put_id(7, 1'b0, 11'd300, 18'd0);
        box_req = 16'h0080;
        select();
        check("R9 setup idx", int'(sel_idx), 7);
        put_id(0, 1'b0, 11'd1, 18'd0);
        box_req = 16'h0001;
        @(negedge clk) begin sel_start = 1'b1; tx_done_ok = 1'b1; end
        @(negedge clk) begin sel_start = 1'b0; tx_done_ok = 1'b0; end
        check("R9 valid after both", int'(sel_valid), 0);
        check("R9 clr of old winner", int'(clr_req), 1 << 7);
        select();
        check("R9 later strobe idx", int'(sel_idx), 0);

        // R10: reset in operation.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid valid", int'(sel_valid), 0);
        check("R10 mid idx", int'(sel_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        report();
    end
endmodule